// File: doc/BRIEF.md
# Mixed-Source Bidirectional I/O Port

This block is an 8-bit bidirectional port bank. A processor reaches it over a byte-wide register bus with separate write and read strobes and a 3-bit register select. Each pin takes its output value from one of two sources. The first is a processor data-out register. The second is a macrocell output from a programmable logic array. A per-pin control bit picks between them. The same control bit also picks the pin's output enable. With the bit clear, the enable comes from a direction register. With the bit set, it comes from a product-term enable supplied by the logic array.

Pins are modelled as separate input, output and output-enable signals. The upper half of the port can be switched to open-drain drive, in which the pin is only ever driven low. The lower half exposes a fast-slew request as a control output. Pin levels pass through a two-flop synchroniser. The synchronised levels feed the processor's data-in register and are also forwarded to the logic array as input-capture values.

Top module: `mixio_port`

## Requirements
- R1: A synchronous reset clears the control, data-out, direction and drive-select registers, the pin output and enable outputs, and the read data. After reset every pin is released.
- R2: Register select codes are: 0 data-in, 1 control, 2 data-out, 3 direction, 4 drive-select and 5 enable-out. Codes 6 and 7 read as zero. A write with `reg_wr` high updates the selected writable register on that clock edge.
- R3: When a pin's control bit is 0, `pin_out` follows the data-out bit. When it is 1, `pin_out` follows `mc_out`. `pin_out` and `pin_oe` are registered, so they show the new value one clock edge after the register or input change.
- R4: When a pin's control bit is 0, the pin enable follows the direction bit. When it is 1, the enable follows `pt_oe`.
- R5: Drive-select bits 0 to 3 appear on `fast_slew`, and bits 4 to 7 appear on `open_drain`. A value of 1 requests that mode.
- R6: A pin from 4 to 7 with its drive-select bit set is enabled only when its output value is 0 and its selected enable is 1. In all other cases the pin is released.
- R7: Pin levels pass through two flops. `imc_out` carries the synchronised levels two edges after a pin change, and a data-in read returns the same levels.
- R8: An enable-out read returns the effective per-pin enable that is currently presented on `pin_oe`.
- R9: Writes to select codes 0, 5, 6 and 7 change no register and no pin output.
- R10: `reg_rdata` loads the selected value on a clock edge where `reg_rd` is high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| mc_out | input | 8 | Macrocell output values from the logic array |
| pt_oe | input | 8 | Product-term output enables from the logic array |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| fast_slew | output | 4 | Fast-slew request, pins 0 to 3 |
| open_drain | output | 4 | Open-drain request, pins 4 to 7 |
| imc_out | output | 8 | Synchronised pin levels to the logic array |

## Verification
Each result has a fixed latency:
- A register write is visible to a read at the edge that follows it.
- A register write reaches `pin_out` and `pin_oe` one edge after the write edge.
- A change on `mc_out` or `pt_oe` reaches the pins at the next edge.
- A change on `pin_in` reaches `imc_out` on the second edge.
- Read data is captured on the edge where the strobe is sampled high.

The bench drives every input on the falling edge. It samples on a later falling edge, after counting exactly those edges. For the synchroniser, it also checks that `imc_out` has not yet changed after only one edge, which rules out a shorter path.

// File: rtl/mixio_pkg.sv
package mixio_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIN  = 3'd0,
    SEL_CTL  = 3'd1,
    SEL_DOUT = 3'd2,
    SEL_DIR  = 3'd3,
    SEL_DRV  = 3'd4,
    SEL_OEN  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/mixio_regfile.sv
module mixio_regfile
  import mixio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] ctl_o,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] drv_o
);
  logic [WIDTH-1:0] ctl_q, dout_q, dir_q, drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_CTL:  ctl_q  <= wdata_i;
        SEL_DOUT: dout_q <= wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_DRV:  drv_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign ctl_o  = ctl_q;
  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign drv_o  = drv_q;

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl_q == '0 && dout_q == '0 && dir_q == '0 && drv_q == '0));

  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i == SEL_CTL) |=> (ctl_q == $past(wdata_i)));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i == SEL_DIR) |=> (dir_q == $past(wdata_i)));

  // R9
  ro_write_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (sel_i == SEL_DIN || sel_i == SEL_OEN || sel_i > SEL_OEN))
    |=> ($stable(ctl_q) && $stable(dout_q) && $stable(dir_q) && $stable(drv_q)));
endmodule

// File: rtl/mixio_pinmux.sv
module mixio_pinmux #(
  parameter int WIDTH     = 8,
  parameter int FAST_PINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] ctl_i,
  input  logic [WIDTH-1:0] dout_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] drv_i,
  input  logic [WIDTH-1:0] mc_i,
  input  logic [WIDTH-1:0] pt_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic val, en, eff;

    always_comb begin
      val = ctl_i[i] ? mc_i[i] : dout_i[i];
      en  = ctl_i[i] ? pt_i[i] : dir_i[i];
    end

    if (i >= FAST_PINS) begin : g_od
      assign eff = en & ~(drv_i[i] & val);

      // R6
      od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o[i] && $past(drv_i[i])) |-> !pin_out_o[i]);
    end else begin : g_pp
      assign eff = en;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out_o[i] <= 1'b0;
        pin_oe_o[i]  <= 1'b0;
      end else begin
        pin_out_o[i] <= val;
        pin_oe_o[i]  <= eff;
      end
    end

    // R3
    src_mc_chk: assert property (@(posedge clk) disable iff (rst)
      ctl_i[i] |=> (pin_out_o[i] == $past(mc_i[i])));

    // R4
    oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctl_i[i] && !dir_i[i]) |=> !pin_oe_o[i]);
  end
endmodule

// File: rtl/mixio_insync.sv
module mixio_insync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stg_q[s] <= '0;
      else if (s == 0)
        stg_q[s] <= pin_i;
      else
        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  // R7
  sync_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stg_q[0] == $past(pin_i)));
endmodule

// File: rtl/mixio_rdmux.sv
module mixio_rdmux
  import mixio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic [WIDTH-1:0] ctl_i,
  input  logic [WIDTH-1:0] dout_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] drv_i,
  input  logic [WIDTH-1:0] oen_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] pick;

  always_comb begin
    case (sel_i)
      SEL_DIN:  pick = din_i;
      SEL_CTL:  pick = ctl_i;
      SEL_DOUT: pick = dout_i;
      SEL_DIR:  pick = dir_i;
      SEL_DRV:  pick = drv_i;
      SEL_OEN:  pick = oen_i;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (rd_i)
      rdata_o <= pick;
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !$past(rst)) |=> $stable(rdata_o));

  // R8
  oen_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == SEL_OEN) |=> (rdata_o == $past(oen_i)));

  // R7
  din_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == SEL_DIN) |=> (rdata_o == $past(din_i)));
endmodule

// File: rtl/mixio_port.sv
module mixio_port
  import mixio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int FAST_PINS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int OD_PINS    = WIDTH - FAST_PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     reg_sel,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [WIDTH-1:0]     reg_wdata,
  output logic [WIDTH-1:0]     reg_rdata,
  input  logic [WIDTH-1:0]     mc_out,
  input  logic [WIDTH-1:0]     pt_oe,
  input  logic [WIDTH-1:0]     pin_in,
  output logic [WIDTH-1:0]     pin_out,
  output logic [WIDTH-1:0]     pin_oe,
  output logic [FAST_PINS-1:0] fast_slew,
  output logic [OD_PINS-1:0]   open_drain,
  output logic [WIDTH-1:0]     imc_out
);
  logic [WIDTH-1:0] ctl, dout, dir, drv, din;

  mixio_regfile #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .sel_i(reg_sel), .wdata_i(reg_wdata),
    .ctl_o(ctl), .dout_o(dout), .dir_o(dir), .drv_o(drv)
  );

  mixio_pinmux #(.WIDTH(WIDTH), .FAST_PINS(FAST_PINS)) mux_i (
    .clk(clk), .rst(rst), .ctl_i(ctl), .dout_i(dout), .dir_i(dir), .drv_i(drv),
    .mc_i(mc_out), .pt_i(pt_oe), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  mixio_insync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin_i(pin_in), .sync_o(din)
  );

  mixio_rdmux #(.WIDTH(WIDTH)) rd_i (
    .clk(clk), .rst(rst), .rd_i(reg_rd), .sel_i(reg_sel), .din_i(din),
    .ctl_i(ctl), .dout_i(dout), .dir_i(dir), .drv_i(drv), .oen_i(pin_oe),
    .rdata_o(reg_rdata)
  );

  assign fast_slew  = drv[FAST_PINS-1:0];
  assign open_drain = drv[WIDTH-1:FAST_PINS];
  assign imc_out    = din;

  // R5
  drv_split_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_DRV) |=> ({open_drain, fast_slew} == $past(reg_wdata)));
endmodule

// File: tb/mixio_port_tb.sv
module mixio_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_sel = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, mc_out = '0, pt_oe = '0, pin_in = '0;
  logic [7:0] reg_rdata, pin_out, pin_oe, imc_out;
  logic [3:0] fast_slew, open_drain;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixio_port dut_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mc_out(mc_out), .pt_oe(pt_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fast_slew(fast_slew),
    .open_drain(open_drain), .imc_out(imc_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [7:0] d);
    reg_sel = sel; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 drive", {open_drain, fast_slew}, 8'h00);
    for (int s = 1; s < 5; s++) begin
      rd_reg(s[2:0], r);
      check("R1 reg read", r, 8'h00);
    end
  endtask

  task automatic t_cpu_mode();
    logic [7:0] r;
    wr_reg(3'd2, 8'hA5);
    wr_reg(3'd3, 8'hFF);
    tick();
    check("R3 cpu pin_out", pin_out, 8'hA5);
    check("R4 dir pin_oe", pin_oe, 8'hFF);
    rd_reg(3'd2, r); check("R2 dout read", r, 8'hA5);
    rd_reg(3'd3, r); check("R2 dir read", r, 8'hFF);
  endtask

  task automatic t_mc_mode();
    logic [7:0] r;
    mc_out = 8'h3C; pt_oe = 8'h0F;
    wr_reg(3'd1, 8'hF0);
    tick();
    check("R3 mixed pin_out", pin_out, 8'h35);
    check("R4 mixed pin_oe", pin_oe, 8'h0F);
    mc_out = 8'hC3; pt_oe = 8'hF0;
    tick();
    check("R3 mc follow", pin_out, 8'hC5);
    check("R4 pt follow", pin_oe, 8'hFF);
    rd_reg(3'd1, r); check("R2 ctl read", r, 8'hF0);
    wr_reg(3'd1, 8'h00);
  endtask

  task automatic t_open_drain();
    logic [7:0] r;
    wr_reg(3'd4, 8'hF5);
    check("R5 fast_slew", {4'h0, fast_slew}, 8'h05);
    check("R5 open_drain", {4'h0, open_drain}, 8'h0F);
    tick();
    check("R6 od pin_oe A5", pin_oe, 8'h5F);
    rd_reg(3'd5, r); check("R8 enout read", r, 8'h5F);
    wr_reg(3'd2, 8'h0F);
    tick();
    check("R6 od pin_oe 0F", pin_oe, 8'hFF);
    check("R6 od pin_out", pin_out, 8'h0F);
    rd_reg(3'd4, r); check("R2 drv read", r, 8'hF5);
  endtask

  task automatic t_input();
    logic [7:0] r;
    pin_in = 8'h96;
    tick();
    check("R7 imc one edge", imc_out, 8'h00);
    tick();
    check("R7 imc two edges", imc_out, 8'h96);
    rd_reg(3'd0, r); check("R7 din read", r, 8'h96);
  endtask

  task automatic t_ro_writes();
    logic [7:0] r;
    wr_reg(3'd0, 8'h11);
    wr_reg(3'd5, 8'h22);
    wr_reg(3'd6, 8'h33);
    wr_reg(3'd7, 8'h44);
    tick();
    check("R9 pin_out kept", pin_out, 8'h0F);
    check("R9 pin_oe kept", pin_oe, 8'hFF);
    rd_reg(3'd1, r); check("R9 ctl kept", r, 8'h00);
    rd_reg(3'd2, r); check("R9 dout kept", r, 8'h0F);
    rd_reg(3'd3, r); check("R9 dir kept", r, 8'hFF);
    rd_reg(3'd4, r); check("R9 drv kept", r, 8'hF5);
    rd_reg(3'd0, r); check("R9 din kept", r, 8'h96);
    rd_reg(3'd6, r); check("R2 unused sel", r, 8'h00);
  endtask

  task automatic t_rd_hold();
    logic [7:0] r;
    rd_reg(3'd2, r);
    wr_reg(3'd2, 8'h77);
    tick();
    check("R10 rdata hold", reg_rdata, 8'h0F);
    rd_reg(3'd2, r);
    check("R10 rdata reload", r, 8'h77);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_cpu_mode();
    t_mc_mode();
    t_open_drain();
    t_input();
    t_ro_writes();
    t_rd_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule